// File: doc/BRIEF.md
# Processor Power State Controller

This block follows a processor core through its power states: running (Normal), halted (Halt), stopped with its clock granted away (Stop Grant), and briefly woken to serve a bus snoop while stopped (Grant Snoop). Two transient states sit on the way into Stop Grant. In the first, the block asks the bus unit to issue the stop-grant acknowledge cycle. In the second, it counts a fixed number of clocks from that cycle's response phase.

Stopping can begin from Normal or from Halt. The block remembers which one it came from, so that when the stop-clock request is released it goes back to Halt if it was halted and to Normal otherwise. Sideband interrupts that arrive while the core is not Normal are caught in one sticky flag per interrupt type. Each flag is handed back as a single one-cycle pulse in the first Normal cycle.

The block reset is synchronous and active high. A reset in Stop Grant clears the internal state but leaves the block stopped. A reset in any other state returns the block to Normal.

Top module: `pwr_state_ctrl`

## Requirements
- R1: The `pwr_state` output uses this encoding: 0 Normal, 1 Halt, 2 waiting for the acknowledge response, 3 counting the entry delay, 4 Stop Grant, 5 Grant Snoop. When `rst` is high at a clock edge and the state is not 4, the next state is 0, `side_rel` is 0 and `ack_cycle_req` is low.
- R2: In Normal, `stop_req_n` low moves the block to state 2, and this takes precedence over `halt_req`. With `stop_req_n` high, `halt_req` moves the block to Halt.
- R3: In Halt, `snoop_hit` leaves the block in Halt. `break_evt` returns it to Normal only while `stop_req_n` is high. With `stop_req_n` low the block moves to state 2 even if `break_evt` is high.
- R4: `ack_cycle_req` is high exactly while the state is 2. An edge with `ack_resp` high in state 2 moves the block to state 3.
- R5: Stop Grant (state 4) is reached at the STOP_DELAY-th clock edge after the edge that sampled `ack_resp` (default 20). Before that edge the state stays 3.
- R6: In Stop Grant with `stop_req_n` low and no snoop, the block stays in Stop Grant. When `stop_req_n` goes high, the block goes to Halt if the stop was requested from Halt, and to Normal otherwise. Release takes precedence over a snoop.
- R7: `snoop_hit` in Stop Grant moves the block to Grant Snoop. `snoop_done` in Grant Snoop moves it back to Stop Grant at the next edge.
- R8: `side_in` bits are sampled in every state except Normal and held in one sticky flag per bit. The bits are: 0 system management, 1 re-init, 2 local line 0, 3 local line 1. Repeated pulses of a bit are kept as one occurrence. On the edge that enters Normal, the flags appear on `side_rel` for exactly one cycle and are then cleared.
- R9: A reset in Stop Grant keeps the state at 4 and clears the sticky flags and the Halt return memory. After the next release the block goes to Normal with `side_rel` equal to 0.
- R10: `side_in` pulses seen while Normal are ignored and never appear on `side_rel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_n | input | 1 | Stop-clock request, active low |
| halt_req | input | 1 | Core asks to halt |
| snoop_hit | input | 1 | Snoop detected on the bus |
| snoop_done | input | 1 | Snoop service finished |
| break_evt | input | 1 | Wake event for Halt |
| ack_resp | input | 1 | Response phase of the acknowledge cycle |
| side_in | input | SIDE_W | Sideband interrupt inputs |
| pwr_state | output | 3 | Current power state code |
| ack_cycle_req | output | 1 | Request to issue the acknowledge cycle |
| side_rel | output | SIDE_W | One-cycle release of latched interrupts |

## Verification
The properties assume `ack_resp` arrives only while `ack_cycle_req` is high. They also assume `snoop_done` is raised only in Grant Snoop and that `stop_req_n` stays low from the moment it is asserted until Stop Grant is reached. The stimulus follows these rules: it pulses the response only in state 2, raises `snoop_done` only after a snoop has been granted, and releases the stop request only once Stop Grant is reached. The one exception is reset, which the stimulus applies freely, including during the entry delay.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int SIDE_W_DEF = 4;
    localparam int STOP_DELAY_DEF = 20;

    typedef enum logic [2:0] {
        PS_NORMAL      = 3'd0,
        PS_HALT        = 3'd1,
        PS_ACK_WAIT    = 3'd2,
        PS_ACK_DELAY   = 3'd3,
        PS_STOP_GRANT  = 3'd4,
        PS_GRANT_SNOOP = 3'd5
    } pwr_state_e;

    typedef struct packed {
        logic stop_n;
        logic halt;
        logic snoop_hit;
        logic snoop_done;
        logic brk;
        logic ack_resp;
    } pwr_req_t;

    // States in which a block reset keeps the current state
    function automatic logic holds_in_reset(pwr_state_e s);
        return s == PS_STOP_GRANT;
    endfunction

endpackage

// File: rtl/pwr_delay_cnt.sv
module pwr_delay_cnt #(
    parameter int DELAY = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(1);
        end else if (run && !done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = (cnt_q == LAST);

endmodule

// File: rtl/pwr_side_latch.sv
module pwr_side_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         release_now,
    input  logic [W-1:0] side_in,
    output logic [W-1:0] side_rel
);
    logic [W-1:0] pend_q;
    logic [W-1:0] rel_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic pend_nxt;
        assign pend_nxt = pend_q[i] | (capture & side_in[i]);

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[i] <= 1'b0;
                rel_q[i]  <= 1'b0;
            end else if (release_now) begin
                pend_q[i] <= 1'b0;
                rel_q[i]  <= pend_nxt;
            end else begin
                pend_q[i] <= pend_nxt;
                rel_q[i]  <= 1'b0;
            end
        end
    end

    assign side_rel = rel_q;

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pwr_req_t   req,
    input  logic       delay_done,
    output pwr_state_e state_q,
    output logic       dly_start,
    output logic       dly_run,
    output logic       wake,
    output logic       ack_req
);
    pwr_state_e nxt;
    logic       ret_halt_q;
    logic       ret_halt_nxt;

    always_comb begin
        nxt          = state_q;
        ret_halt_nxt = ret_halt_q;
        dly_start    = 1'b0;
        case (state_q)
            PS_NORMAL: begin
                if (!req.stop_n) begin
                    nxt          = PS_ACK_WAIT;
                    ret_halt_nxt = 1'b0;
                end else if (req.halt) begin
                    nxt = PS_HALT;
                end
            end
            PS_HALT: begin
                if (!req.stop_n) begin
                    nxt          = PS_ACK_WAIT;
                    ret_halt_nxt = 1'b1;
                end else if (req.brk) begin
                    nxt = PS_NORMAL;
                end
            end
            PS_ACK_WAIT: begin
                if (req.ack_resp) begin
                    nxt       = PS_ACK_DELAY;
                    dly_start = 1'b1;
                end
            end
            PS_ACK_DELAY: begin
                if (delay_done) nxt = PS_STOP_GRANT;
            end
            PS_STOP_GRANT: begin
                if (req.stop_n) begin
                    nxt = ret_halt_q ? PS_HALT : PS_NORMAL;
                end else if (req.snoop_hit) begin
                    nxt = PS_GRANT_SNOOP;
                end
            end
            PS_GRANT_SNOOP: begin
                if (req.snoop_done) nxt = PS_STOP_GRANT;
            end
            default: nxt = PS_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_halt_q <= 1'b0;
            if (!holds_in_reset(state_q)) state_q <= PS_NORMAL;
        end else begin
            ret_halt_q <= ret_halt_nxt;
            state_q    <= nxt;
        end
    end

    assign dly_run = (state_q == PS_ACK_DELAY);
    assign ack_req = (state_q == PS_ACK_WAIT);
    assign wake    = (state_q != PS_NORMAL) && (nxt == PS_NORMAL);

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int STOP_DELAY = STOP_DELAY_DEF,
    parameter int SIDE_W     = SIDE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_req_n,
    input  logic              halt_req,
    input  logic              snoop_hit,
    input  logic              snoop_done,
    input  logic              break_evt,
    input  logic              ack_resp,
    input  logic [SIDE_W-1:0] side_in,
    output logic [2:0]        pwr_state,
    output logic              ack_cycle_req,
    output logic [SIDE_W-1:0] side_rel
);
    pwr_req_t   req;
    pwr_state_e st;
    logic       dly_start;
    logic       dly_run;
    logic       dly_done;
    logic       wake;

    assign req = '{stop_n:     stop_req_n,
                   halt:       halt_req,
                   snoop_hit:  snoop_hit,
                   snoop_done: snoop_done,
                   brk:        break_evt,
                   ack_resp:   ack_resp};

    pwr_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .delay_done (dly_done),
        .state_q    (st),
        .dly_start  (dly_start),
        .dly_run    (dly_run),
        .wake       (wake),
        .ack_req    (ack_cycle_req)
    );

    pwr_delay_cnt #(.DELAY(STOP_DELAY)) u_dly (
        .clk   (clk),
        .rst   (rst),
        .start (dly_start),
        .run   (dly_run),
        .done  (dly_done)
    );

    pwr_side_latch #(.W(SIDE_W)) u_side (
        .clk         (clk),
        .rst         (rst),
        .capture     (st != PS_NORMAL),
        .release_now (wake),
        .side_in     (side_in),
        .side_rel    (side_rel)
    );

    assign pwr_state = st;

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
    import pwr_pkg::*;
#(
    parameter int STOP_DELAY = STOP_DELAY_DEF,
    parameter int SIDE_W     = SIDE_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_req_n,
    input logic              snoop_hit,
    input logic              snoop_done,
    input logic              ack_resp,
    input logic [2:0]        pwr_state,
    input logic              ack_cycle_req,
    input logic [SIDE_W-1:0] side_rel
);
    int dly_seen;

    always_ff @(posedge clk) begin
        if (rst) dly_seen <= 0;
        else if (pwr_state == PS_ACK_DELAY) dly_seen <= dly_seen + 1;
        else dly_seen <= 0;
    end

    // R4
    ack_to_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_cycle_req && ack_resp) |=> (pwr_state == PS_ACK_DELAY));

    // R5
    entry_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_STOP_GRANT && $past(pwr_state) == PS_ACK_DELAY)
        |-> (dly_seen == STOP_DELAY));

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_STOP_GRANT && !stop_req_n && !snoop_hit)
        |=> (pwr_state == PS_STOP_GRANT));

    // R7
    snoop_back_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_GRANT_SNOOP && snoop_done) |=> (pwr_state == PS_STOP_GRANT));

    // R8
    release_when_chk: assert property (@(posedge clk) disable iff (rst)
        (side_rel != '0) |-> (pwr_state == PS_NORMAL && $past(pwr_state) != PS_NORMAL));

    // R8
    release_once_chk: assert property (@(posedge clk) disable iff (rst)
        (side_rel != '0) |=> (side_rel == '0));

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(
    .STOP_DELAY (STOP_DELAY),
    .SIDE_W     (SIDE_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .stop_req_n    (stop_req_n),
    .snoop_hit     (snoop_hit),
    .snoop_done    (snoop_done),
    .ack_resp      (ack_resp),
    .pwr_state     (pwr_state),
    .ack_cycle_req (ack_cycle_req),
    .side_rel      (side_rel)
);

// File: tb/pwr_state_ctrl_tb.sv
module pwr_state_ctrl_tb;
    import pwr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DLY = 20;
    localparam int SW  = 4;

    logic          clk = 1'b0;
    logic          rst, stop_req_n, halt_req, snoop_hit, snoop_done, break_evt, ack_resp;
    logic [SW-1:0] side_in;
    logic [2:0]    pwr_state;
    logic          ack_cycle_req;
    logic [SW-1:0] side_rel;

    typedef struct {
        logic [2:0]    st;
        logic          ack;
        logic [SW-1:0] rel;
        string         req;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    bit   finished = 0;

    pwr_state_ctrl #(.STOP_DELAY(DLY), .SIDE_W(SW)) u_dut (
        .clk (clk), .rst (rst), .stop_req_n (stop_req_n), .halt_req (halt_req),
        .snoop_hit (snoop_hit), .snoop_done (snoop_done), .break_evt (break_evt),
        .ack_resp (ack_resp), .side_in (side_in), .pwr_state (pwr_state),
        .ack_cycle_req (ack_cycle_req), .side_rel (side_rel)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Monitor: compares outputs just after each edge with the queued item
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (pwr_state !== e.st || ack_cycle_req !== e.ack || side_rel !== e.rel) begin
                errors++;
                $display("FAIL %s: state=%0d ack=%0b rel=%b expected state=%0d ack=%0b rel=%b",
                         e.req, pwr_state, ack_cycle_req, side_rel, e.st, e.ack, e.rel);
            end
        end
    end

    // Driver: inputs are already applied; queue what the next edge must produce
    task automatic step(input logic [2:0] st, input logic ack,
                        input logic [SW-1:0] rel, input string req);
        exp_t e;
        e.st = st; e.ack = ack; e.rel = rel; e.req = req;
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_delay();
        ack_resp = 1'b1;
        step(PS_ACK_DELAY, 1'b0, '0, "R4");
        ack_resp = 1'b0;
        for (int k = 1; k < DLY; k++) step(PS_ACK_DELAY, 1'b0, '0, "R5");
        step(PS_STOP_GRANT, 1'b0, '0, "R5");
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: state=%0d expected run to finish", pwr_state);
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; stop_req_n = 1'b1; halt_req = 1'b0; snoop_hit = 1'b0;
        snoop_done = 1'b0; break_evt = 1'b0; ack_resp = 1'b0; side_in = '0;
        @(negedge clk);
        step(PS_NORMAL, 1'b0, '0, "R1");
        step(PS_NORMAL, 1'b0, '0, "R1");
        rst = 1'b0;

        // R10: interrupts in Normal are ignored
        side_in = 4'hF; step(PS_NORMAL, 1'b0, '0, "R10");
        side_in = '0;   step(PS_NORMAL, 1'b0, '0, "R10");

        // R2, R3: halt, snoop in halt, break
        halt_req = 1'b1;  step(PS_HALT, 1'b0, '0, "R2");
        halt_req = 1'b0;  snoop_hit = 1'b1; step(PS_HALT, 1'b0, '0, "R3");
        snoop_hit = 1'b0; break_evt = 1'b1; step(PS_NORMAL, 1'b0, '0, "R3");
        break_evt = 1'b0;

        // R2: stop wins over halt in Normal
        halt_req = 1'b1; stop_req_n = 1'b0; step(PS_ACK_WAIT, 1'b1, '0, "R2");
        halt_req = 1'b0; step(PS_ACK_WAIT, 1'b1, '0, "R4");
        run_delay();

        // R8: collapse and latch in Stop Grant and Grant Snoop
        side_in = 4'b0001; step(PS_STOP_GRANT, 1'b0, '0, "R8");
        side_in = '0;      step(PS_STOP_GRANT, 1'b0, '0, "R8");
        side_in = 4'b0001; step(PS_STOP_GRANT, 1'b0, '0, "R8");
        side_in = 4'b0100; step(PS_STOP_GRANT, 1'b0, '0, "R8");
        side_in = '0;
        snoop_hit = 1'b1;  step(PS_GRANT_SNOOP, 1'b0, '0, "R7");
        snoop_hit = 1'b0;  side_in = 4'b1000; step(PS_GRANT_SNOOP, 1'b0, '0, "R7");
        side_in = '0;      snoop_done = 1'b1; step(PS_STOP_GRANT, 1'b0, '0, "R7");
        snoop_done = 1'b0; step(PS_STOP_GRANT, 1'b0, '0, "R6");
        stop_req_n = 1'b1; step(PS_NORMAL, 1'b0, 4'b1101, "R8");
        step(PS_NORMAL, 1'b0, '0, "R8");

        // R3, R6: stop from Halt returns to Halt
        halt_req = 1'b1; step(PS_HALT, 1'b0, '0, "R2");
        halt_req = 1'b0; stop_req_n = 1'b0; break_evt = 1'b1;
        step(PS_ACK_WAIT, 1'b1, '0, "R3");
        break_evt = 1'b0;
        run_delay();
        side_in = 4'b0010; step(PS_STOP_GRANT, 1'b0, '0, "R8");
        side_in = '0; stop_req_n = 1'b1; step(PS_HALT, 1'b0, '0, "R6");
        break_evt = 1'b1; step(PS_NORMAL, 1'b0, 4'b0010, "R8");
        break_evt = 1'b0; step(PS_NORMAL, 1'b0, '0, "R8");

        // R9: reset in Stop Grant
        halt_req = 1'b1; step(PS_HALT, 1'b0, '0, "R2");
        halt_req = 1'b0; stop_req_n = 1'b0; step(PS_ACK_WAIT, 1'b1, '0, "R3");
        run_delay();
        side_in = 4'b0001; step(PS_STOP_GRANT, 1'b0, '0, "R8");
        side_in = '0; rst = 1'b1; step(PS_STOP_GRANT, 1'b0, '0, "R9");
        rst = 1'b0; stop_req_n = 1'b1; step(PS_NORMAL, 1'b0, '0, "R9");
        step(PS_NORMAL, 1'b0, '0, "R9");

        // R1: reset outside Stop Grant
        stop_req_n = 1'b0; step(PS_ACK_WAIT, 1'b1, '0, "R4");
        ack_resp = 1'b1;   step(PS_ACK_DELAY, 1'b0, '0, "R4");
        ack_resp = 1'b0;   rst = 1'b1; step(PS_NORMAL, 1'b0, '0, "R1");
        rst = 1'b0; stop_req_n = 1'b1; step(PS_NORMAL, 1'b0, '0, "R1");
        halt_req = 1'b1;   step(PS_HALT, 1'b0, '0, "R2");
        halt_req = 1'b0;   rst = 1'b1; step(PS_NORMAL, 1'b0, '0, "R1");
        rst = 1'b0;

        @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

endmodule